// File: doc/BRIEF.md
# Programmable-Framing Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. A write strobe drops a byte into a one-entry holding register. At the next oversampling tick the byte moves into a shift stage, which sends a low start bit, the data bits least significant first, an optional parity bit and then one or more high stop bits. The host can refill the holding register while a frame is on the line, and the next frame then follows the stop bits with no idle gap.

Framing comes from static configuration inputs: a 2-bit word-length code, a parity enable, even or odd parity, and a long-stop select. The shift stage captures these inputs when it loads a byte, so they may change while a frame is in flight. Bit timing uses a tick enable that fires once every `divisor` clock cycles, and each serial bit lasts 16 ticks. A divisor of zero is defined as "tick held off": the transmitter freezes in place until a non-zero divisor is applied.

Top module: `sertx_top`

## Requirements
- R1: During reset and after reset is released, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A frame is a start bit (`txd`=0), then the data bits starting with bit 0, then the parity bit if parity is enabled, then the stop bits (`txd`=1). When no frame is in progress the line rests at 1.
- R3: `cfg_wlen` sets the number of data bits sent: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of the byte are not sent.
- R4: With `cfg_par_en`=1, the parity bit follows the last data bit. It is the XOR of the sent data bits only when `cfg_par_even`=1, and the inverse of that XOR when `cfg_par_even`=0. With `cfg_par_en`=0 no parity bit is sent.
- R5: With `cfg_stop_long`=0 the stop time is 16 ticks. With `cfg_stop_long`=1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R6: A non-zero `divisor` N (1 to 65535) gives one tick every N clock cycles. Every start, data and parity bit lasts exactly 16 ticks (16·N cycles).
- R7: While `divisor` is 0 no tick occurs. `txd` holds its value and a waiting byte stays in the holding register.
- R8: `hold_empty` goes low in the cycle after a write. It returns high on the same clock edge on which the byte enters the shift stage, and that is the edge on which the start bit begins.
- R9: `tx_empty` is low from the cycle after a write until the final stop tick has elapsed. It then goes high if no byte is waiting.
- R10: If a byte is waiting when the stop time ends, its start bit begins on that same edge, with no idle time between the frames.
- R11: The framing configuration is captured when a byte is loaded. Changing the configuration inputs during a frame has no effect on that frame.
- R12: A write while the holding register is full replaces the waiting byte, so only the most recent byte is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_wlen | input | 2 | Word length code (00=5 … 11=8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop_long | input | 1 | 0 = one stop bit, 1 = 1.5 (5-bit) or 2 stop bits |
| divisor | input | 16 | Clock cycles per oversampling tick; 0 stops ticking |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | No byte waiting and no frame on the line |

## Verification
Several invariants are checked on every cycle. The line is high whenever the transmitter reports empty. A rising `hold_empty` always coincides with a low start bit. `hold_empty` and `tx_empty` only fall after a write. The line never moves while the divisor is zero. The behaviours that depend on the data only the scenarios can show: bit order, word-length masking, parity polarity, exact bit and stop durations in cycles, back-to-back chaining, configuration capture and overwrite of a waiting byte. The bench sweeps every word length, parity mode and stop setting at two divisors and decodes each frame at computed bit centres and boundaries.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       stop_long;
  } frame_cfg_t;

endpackage

// File: rtl/sertx_tick_gen.sv
module sertx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_zero;

  assign div_zero = (divisor == '0);
  // ">=" keeps the count bounded when the divisor is lowered mid-count
  assign tick     = !div_zero && (cnt_q >= (divisor - DIV_W'(1)));

  always_comb begin
    cnt_d = cnt_q + DIV_W'(1);
    if (div_zero || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);

  logic full_d;

  always_comb begin
    full_d = hold_full;
    if (take)   full_d = 1'b0;
    if (wr_stb) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_full <= 1'b0;
    else        hold_full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_data <= '0;
    else if (wr_stb) hold_data <= wr_data;
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg_in,
  output logic              take,
  output logic              txd,
  output logic              busy
);

  localparam int CNT_W  = $clog2(2 * OVERSAMPLE);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] STOP15_LST = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] STOP2_LST  = CNT_W'(2 * OVERSAMPLE - 1);
  localparam logic [BIDX_W-1:0] BIDX_BASE = BIDX_W'(DATA_W - 4);

  tx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   tcnt_q, tcnt_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  frame_cfg_t         cfg_q, cfg_d;
  logic               par_q, par_d;

  logic [BIDX_W-1:0]  last_in, last_q;
  logic [DATA_W-1:0]  mask_in;
  logic               par_calc;
  logic [CNT_W-1:0]   stop_last;
  logic               bit_end;

  assign last_in = BIDX_W'(cfg_in.wlen) + BIDX_BASE;
  assign last_q  = BIDX_W'(cfg_q.wlen) + BIDX_BASE;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask_in[i] = (i <= int'(last_in));
  end

  assign par_calc = (^(hold_data & mask_in)) ^ ~cfg_in.par_even;
  assign bit_end  = (tcnt_q == BIT_LAST);

  always_comb begin
    if (!cfg_q.stop_long)     stop_last = BIT_LAST;
    else if (cfg_q.wlen == 0) stop_last = STOP15_LST;
    else                      stop_last = STOP2_LST;
  end

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    cfg_d  = cfg_q;
    par_d  = par_q;
    take   = 1'b0;
    if (tick) begin
      tcnt_d = tcnt_q + CNT_W'(1);
      unique case (st_q)
        ST_IDLE: tcnt_d = '0;
        ST_START: begin
          if (bit_end) begin
            st_d   = ST_DATA;
            tcnt_d = '0;
            bidx_d = '0;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            tcnt_d = '0;
            sh_d   = sh_q >> 1;
            if (bidx_q == last_q) st_d = cfg_q.par_en ? ST_PAR : ST_STOP;
            else                  bidx_d = bidx_q + BIDX_W'(1);
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            st_d   = ST_STOP;
            tcnt_d = '0;
          end
        end
        ST_STOP: begin
          if (tcnt_q == stop_last) begin
            st_d   = ST_IDLE;
            tcnt_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      // load from idle, or chain straight off the final stop tick
      if (hold_full && (st_d == ST_IDLE)) begin
        take   = 1'b1;
        st_d   = ST_START;
        tcnt_d = '0;
        sh_d   = hold_data;
        cfg_d  = cfg_in;
        par_d  = par_calc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      cfg_q  <= '0;
      par_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      cfg_q  <= cfg_d;
      par_q  <= par_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_stop_long,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              tick;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  frame_cfg_t        cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en,
                    par_even: cfg_par_even, stop_long: cfg_stop_long};

  sertx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .divisor(divisor), .tick(tick)
  );

  sertx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .hold_full(hold_full), .hold_data(hold_data)
  );

  sertx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .hold_full(hold_full),
    .hold_data(hold_data), .cfg_in(cfg_in), .take(take), .txd(txd),
    .busy(busy)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic [DIV_W-1:0] divisor,
  input logic             txd,
  input logic             hold_empty,
  input logic             tx_empty
);

  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_take_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> !txd);

  assert_fill_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr_stb));

  assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_stb));

  assert_div_zero_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> $stable(txd));

endmodule

bind sertx_top sertx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .divisor(divisor),
  .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_stb;
  logic [7:0]  wr_data;
  logic [1:0]  cfg_wlen;
  logic        cfg_par_en;
  logic        cfg_par_even;
  logic        cfg_stop_long;
  logic [15:0] divisor;
  logic        txd;
  logic        hold_empty;
  logic        tx_empty;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  sertx_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop_long(cfg_stop_long), .divisor(divisor), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(inout int pos, input int target);
    while (pos < target) begin
      @(negedge clk);
      pos++;
    end
  endtask

  // mode 0: configure, write d, wait start; 1: configure, wait start; 2: start already seen
  task automatic check_frame(input logic [7:0] d, input logic [1:0] wl,
                             input logic pe, input logic pev, input logic sl,
                             input int div, input int mode, input bit mangle,
                             input bit q_en, input logic [7:0] q);
    int nb     = 5 + int'(wl);
    int p      = pe ? 1 : 0;
    int sticks = !sl ? 16 : ((wl == 2'd0) ? 24 : 32);
    int bitc   = 16 * div;
    int pos    = 0;
    int waited = 0;
    int s0;
    int total;
    logic expar;
    if (mode != 2) begin
      cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = pev; cfg_stop_long = sl;
      divisor  = 16'(div);
    end
    if (mode == 0) begin
      while (!tx_empty) @(negedge clk);
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      chk("R8 hold_empty low after write", int'(hold_empty), 0);
      chk("R9 tx_empty low after write", int'(tx_empty), 0);
    end
    if (mode != 2) begin
      while (txd && waited < bitc + 40) begin
        @(negedge clk);
        waited++;
      end
      chk("R2 start bit appears", int'(txd), 0);
    end
    chk("R8 hold_empty high at load", int'(hold_empty), 1);
    adv(pos, bitc / 2);
    chk("R2 start bit low", int'(txd), 0);
    if (mangle) begin
      cfg_wlen = ~wl; cfg_par_en = ~pe; cfg_par_even = ~pev; cfg_stop_long = ~sl;
    end
    if (q_en) begin
      wr_stb = 1'b1; wr_data = q;
      @(negedge clk);
      pos++;
      wr_stb = 1'b0;
    end
    adv(pos, bitc - 1);
    chk("R6 start lasts 16 ticks", int'(txd), 0);
    for (int j = 0; j < nb; j++) begin
      adv(pos, bitc * (1 + j) + bitc / 2);
      chk($sformatf("R3 data bit %0d (R2 order, R11 capture)", j), int'(txd), int'(d[j]));
    end
    expar = ~pev;
    for (int j = 0; j < nb; j++) expar = expar ^ d[j];
    if (pe) begin
      adv(pos, bitc * (1 + nb) + bitc / 2);
      chk("R4 parity bit", int'(txd), int'(expar));
    end
    s0 = bitc * (1 + nb + p);
    adv(pos, s0);
    chk("R5 stop begins high (R4 no extra bit)", int'(txd), 1);
    total = s0 + sticks * div;
    adv(pos, total - 1);
    chk("R5 stop still running", int'(txd), 1);
    chk("R9 tx_empty low in last stop cycle", int'(tx_empty), 0);
    adv(pos, total);
    if (q_en) begin
      chk("R10 next start immediate", int'(txd), 0);
      chk("R10 waiting byte taken", int'(hold_empty), 1);
    end else begin
      chk("R9 tx_empty high after stop", int'(tx_empty), 1);
      chk("R5 line idle after stop", int'(txd), 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
    cfg_wlen = 2'b11; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_stop_long = 1'b0;
    divisor = 16'd1;
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", int'(txd), 1);
    chk("R1 hold_empty in reset", int'(hold_empty), 1);
    chk("R1 tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 txd after reset", int'(txd), 1);
    chk("R1 hold_empty after reset", int'(hold_empty), 1);
    chk("R1 tx_empty after reset", int'(tx_empty), 1);

    // full sweep of framing at two divisors (R2 R3 R4 R5 R6 R8 R9)
    foreach (u_div_list[k]) begin
      for (int wl = 0; wl < 4; wl++)
        for (int pm = 0; pm < 3; pm++)
          for (int sl = 0; sl < 2; sl++)
            check_frame(8'(8'hA5 ^ (wl * 37 + pm * 11 + sl * 5 + k * 3)),
                        2'(wl), pm != 0, pm == 2, sl != 0,
                        u_div_list[k], 0, 1'b0, 1'b0, 8'h00);
    end

    // R6 larger divisor
    check_frame(8'h6B, 2'b11, 1'b0, 1'b0, 1'b0, 300, 0, 1'b0, 1'b0, 8'h00);

    // R11 configuration changed mid-frame
    check_frame(8'hD2, 2'b01, 1'b1, 1'b0, 1'b0, 2, 0, 1'b1, 1'b0, 8'h00);

    // R10 back-to-back frames
    check_frame(8'h3E, 2'b10, 1'b1, 1'b1, 1'b1, 2, 0, 1'b0, 1'b1, 8'hC7);
    check_frame(8'hC7, 2'b10, 1'b1, 1'b1, 1'b1, 2, 2, 1'b0, 1'b0, 8'h00);

    // R7 divisor 0 freezes, R12 overwrite while full
    divisor = 16'd0;
    while (!tx_empty) @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_data = 8'h3C;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (500) @(negedge clk);
    chk("R7 line frozen with divisor 0", int'(txd), 1);
    chk("R7 byte still waiting", int'(hold_empty), 0);
    chk("R7 tx_empty low while waiting", int'(tx_empty), 0);
    check_frame(8'h3C, 2'b11, 1'b1, 1'b0, 1'b0, 2, 1, 1'b0, 1'b0, 8'h00);
    repeat (40) @(negedge clk);
    chk("R12 only latest byte sent", int'(tx_empty), 1);
    chk("R12 line idle", int'(txd), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int u_div_list[2] = '{1, 3};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule